// File: doc/BRIEF.md
# LCD Row Scan Timing Generator

This block turns the display's internal scan clock into the row timing of an eight-row multiplexed LCD. Each frame has eight row periods of four clock cycles each, so the clock runs at 32 times the frame rate. For every row period the block presents the display-memory row to read. It also gives a one-cycle load strobe so that the row's segment data can be captured into the segment latch. Frame sync is a level that changes once per frame, so it runs at half the frame rate and its level marks frame A (low) or frame B (high).

Up to four drivers can share one panel. Two chip-select straps choose the role. With both straps low, the chip is the master: it drives frame sync and owns the frame timing. Any other strap value makes it a slave, which leaves frame sync undriven and realigns its counters on every change of the frame-sync input. A functional power-on reset (`por`) and a blanking input (`blank`) both stop the scan. When the scan stops, memory reads stop and the row address is held at zero. When the input that stopped the scan is released, the block runs a fixed restart: the master emits a frame-sync change, starts again at row 000 and loads row 001 one row period later. The scan clock is the same clock in every chip, because the slaves run from the master's oscillator.

The control FSM has three states:
- HOLD: reset or blank is active.
- ARM: a slave has been released and waits for the first frame-sync change.
- SCAN: rows are being scanned.

Its transitions are:
- RELEASE_MASTER: HOLD to SCAN, with a frame-sync change.
- RELEASE_SLAVE: HOLD to ARM.
- LOCK: ARM to SCAN, on a frame-sync change.
- STOP: ARM or SCAN to HOLD, while blank is high.
- RESYNC: SCAN to SCAN, when a slave sees a frame-sync change.
- WRAP: SCAN to SCAN, at the end of row 7.

Reset forces HOLD from any state.

Top module: `lcd_scan_timing`

## Requirements
- R1: `fsync_oe` is 1 exactly when `strap_sel` is 2'b00 (master); every other strap value gives 0 (slave).
- R2: While `por` is high, at each clock edge the block returns to its idle state: `row_addr`=0, `row_load`=0, `phase_b`=0, `fsync_out`=0.
- R3: At the first clock edge where a master samples both `por` and `blank` low after either was high, `fsync_out` inverts and `row_addr` becomes 000.
- R4: After a `por` release the first frame is frame B (`phase_b`=1, `fsync_out`=1).
- R5: Each row lasts 4 clock cycles, and `row_addr` steps 0,1,...,7 and then wraps to 0.
- R6: `row_load` is a single-cycle pulse in the first cycle of each row period. After a restart there is no pulse for row 000; the first pulse is for row 001, 4 cycles after the frame-sync change.
- R7: In the master, `fsync_out` inverts only when row 7 wraps to row 0, so it has a period of 64 cycles. `phase_b` equals `fsync_out`.
- R8: While `blank` is high, `row_load` stays 0, `row_addr` stays 0 and `phase_b`/`fsync_out` hold their value.
- R9: A released slave produces no `row_load` until its `fsync_in` changes level.
- R10: When a slave sees `fsync_in` change in cycle m, its row timing matches a master whose frame-sync change became visible in cycle m. Row k loads in cycle m+4k, and `phase_b` takes the new `fsync_in` level from cycle m+1.
- R11: A slave already scanning realigns its row and cycle counters on every `fsync_in` change, including changes in the middle of a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock (32 per frame) |
| strap_sel | input | 2 | Chip-select straps; 2'b00 selects master |
| blank | input | 1 | High stops display reads and the scan |
| por | input | 1 | Functional power-on reset, active high, synchronous |
| fsync_in | input | 1 | Frame sync from the master (used by slaves) |
| row_addr | output | 3 | Display-memory row being read |
| row_load | output | 1 | One-cycle strobe to capture the row into the segment latch |
| phase_b | output | 1 | Frame phase: 1 for frame B, 0 for frame A |
| fsync_out | output | 1 | Frame sync level driven by the master |
| fsync_oe | output | 1 | Drive enable for frame sync (master only) |

## Verification
Most internal faults show up at the strobe within one row period, which is four cycles:
- A wrong cycle-in-row count moves the strobe or drops it.
- A wrong row count gives the wrong row address at the next strobe.
- A missing suppression flag on restart gives an extra strobe for row 000.

A phase fault is slower to appear. It shows only at the next frame boundary, up to 32 cycles later, as a frame-sync change that is missing or early. The scoreboard therefore compares every strobe against the expected cycle, row and phase over several frames. It also treats any strobe during blank or before a slave locks as an error.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_ARM  = 2'd1,
        ST_SCAN = 2'd2
    } scan_state_t;

    typedef enum logic [1:0] {
        CNT_ZERO   = 2'd0,
        CNT_START0 = 2'd1,
        CNT_START1 = 2'd2,
        CNT_RUN    = 2'd3
    } cnt_cmd_t;

endpackage

// File: rtl/lcd_scan_counter.sv
module lcd_scan_counter
    import lcd_scan_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int TICKS = 4
) (
    input  logic                    clk,
    input  logic                    por,
    input  cnt_cmd_t                cmd,
    output logic [$clog2(ROWS)-1:0] row,
    output logic                    tick_zero,
    output logic                    row_end,
    output logic                    frame_end
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int TICK_W = $clog2(TICKS);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    logic [TICK_W-1:0] tick;

    always_ff @(posedge clk) begin
        if (por) begin
            tick <= '0;
            row  <= '0;
        end else begin
            unique case (cmd)
                CNT_ZERO, CNT_START0: begin
                    tick <= '0;
                    row  <= '0;
                end
                CNT_START1: begin
                    // the slave sees the sync change one cycle late
                    tick <= TICK_W'(1);
                    row  <= '0;
                end
                CNT_RUN: begin
                    if (tick == TICK_LAST) begin
                        tick <= '0;
                        row  <= (row == ROW_LAST) ? '0 : row + ROW_W'(1);
                    end else begin
                        tick <= tick + TICK_W'(1);
                    end
                end
                default: begin
                    tick <= '0;
                    row  <= '0;
                end
            endcase
        end
    end

    always_comb begin
        tick_zero = (tick == '0);
        row_end   = (tick == TICK_LAST);
        frame_end = (tick == TICK_LAST) && (row == ROW_LAST);
    end

endmodule

// File: rtl/lcd_sync_detect.sv
module lcd_sync_detect (
    input  logic clk,
    input  logic por,
    input  logic fsync_in,
    output logic sync_edge,
    output logic sync_level
);
    logic fsync_q;

    always_ff @(posedge clk) begin
        // while in reset, track the input so that release makes no false edge
        fsync_q <= fsync_in;
    end

    always_comb begin
        sync_edge  = (fsync_in != fsync_q) && !por;
        sync_level = fsync_in;
    end

endmodule

// File: rtl/lcd_scan_fsm.sv
module lcd_scan_fsm
    import lcd_scan_pkg::*;
(
    input  logic     clk,
    input  logic     por,
    input  logic     blank,
    input  logic     is_master,
    input  logic     sync_edge,
    input  logic     sync_level,
    input  logic     tick_zero,
    input  logic     row_end,
    input  logic     frame_end,
    output cnt_cmd_t cmd,
    output logic     row_load,
    output logic     phase_b
);
    scan_state_t state, state_nxt;
    logic        phase, phase_nxt;
    logic        first, first_nxt;

    // next state, counter command and phase
    always_comb begin
        state_nxt = state;
        phase_nxt = phase;
        first_nxt = first;
        cmd       = CNT_ZERO;
        unique case (state)
            ST_HOLD: begin
                if (!blank) begin
                    if (is_master) begin
                        // RELEASE_MASTER
                        state_nxt = ST_SCAN;
                        cmd       = CNT_START0;
                        phase_nxt = ~phase;
                        first_nxt = 1'b1;
                    end else begin
                        // RELEASE_SLAVE
                        state_nxt = ST_ARM;
                    end
                end
            end
            ST_ARM: begin
                if (blank) begin
                    state_nxt = ST_HOLD;          // STOP
                end else if (sync_edge) begin
                    state_nxt = ST_SCAN;          // LOCK
                    cmd       = CNT_START1;
                    phase_nxt = sync_level;
                    first_nxt = 1'b1;
                end
            end
            ST_SCAN: begin
                if (blank) begin
                    state_nxt = ST_HOLD;          // STOP
                end else begin
                    cmd = CNT_RUN;
                    if (row_end) begin
                        first_nxt = 1'b0;
                    end
                    if (is_master) begin
                        if (frame_end) begin
                            phase_nxt = ~phase;   // WRAP
                        end
                    end else if (sync_edge) begin
                        cmd       = CNT_START1;   // RESYNC
                        phase_nxt = sync_level;
                    end
                end
            end
            default: begin
                state_nxt = ST_HOLD;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (por) begin
            state <= ST_HOLD;
            phase <= 1'b0;
            first <= 1'b0;
        end else begin
            state <= state_nxt;
            phase <= phase_nxt;
            first <= first_nxt;
        end
    end

    // outputs
    always_comb begin
        row_load = (state == ST_SCAN) && tick_zero && !first;
        phase_b  = phase;
    end

endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
    import lcd_scan_pkg::*;
#(
    parameter int ROWS          = 8,
    parameter int TICKS_PER_ROW = 4
) (
    input  logic                    clk,
    input  logic [1:0]              strap_sel,
    input  logic                    blank,
    input  logic                    por,
    input  logic                    fsync_in,
    output logic [$clog2(ROWS)-1:0] row_addr,
    output logic                    row_load,
    output logic                    phase_b,
    output logic                    fsync_out,
    output logic                    fsync_oe
);
    cnt_cmd_t cmd;
    logic     is_master;
    logic     sync_edge, sync_level;
    logic     tick_zero, row_end, frame_end;

    assign is_master = (strap_sel == 2'b00);

    lcd_sync_detect i_sync (
        .clk        (clk),
        .por        (por),
        .fsync_in   (fsync_in),
        .sync_edge  (sync_edge),
        .sync_level (sync_level)
    );

    lcd_scan_counter #(
        .ROWS  (ROWS),
        .TICKS (TICKS_PER_ROW)
    ) i_cnt (
        .clk       (clk),
        .por       (por),
        .cmd       (cmd),
        .row       (row_addr),
        .tick_zero (tick_zero),
        .row_end   (row_end),
        .frame_end (frame_end)
    );

    lcd_scan_fsm i_fsm (
        .clk        (clk),
        .por        (por),
        .blank      (blank),
        .is_master  (is_master),
        .sync_edge  (sync_edge),
        .sync_level (sync_level),
        .tick_zero  (tick_zero),
        .row_end    (row_end),
        .frame_end  (frame_end),
        .cmd        (cmd),
        .row_load   (row_load),
        .phase_b    (phase_b)
    );

    assign fsync_out = phase_b;
    assign fsync_oe  = is_master;

endmodule

// File: rtl/lcd_scan_timing_chk.sv
module lcd_scan_timing_chk #(
    parameter int ROW_W = 3
) (
    input logic             clk,
    input logic             por,
    input logic             blank,
    input logic             fsync_oe,
    input logic             fsync_out,
    input logic [ROW_W-1:0] row_addr,
    input logic             row_load
);
    // R5: a nonzero row is always its predecessor plus one
    a_r5_row_step: assert property (@(posedge clk) disable iff (por)
        (!$stable(row_addr) && row_addr != '0) |-> (row_addr == ROW_W'($past(row_addr) + 1)));

    // R6: the load strobe lasts one cycle
    a_r6_load_single: assert property (@(posedge clk) disable iff (por)
        row_load |=> !row_load);

    // R7: the master changes frame sync only at row 0
    a_r7_sync_at_row0: assert property (@(posedge clk) disable iff (por)
        (fsync_oe && !$stable(fsync_out)) |-> (row_addr == '0));

    // R8: blank stops reads and parks the row
    a_r8_blank_quiet: assert property (@(posedge clk) disable iff (por)
        blank |=> (!row_load && row_addr == '0));

endmodule

bind lcd_scan_timing lcd_scan_timing_chk #(.ROW_W($clog2(ROWS))) i_chk (
    .clk       (clk),
    .por       (por),
    .blank     (blank),
    .fsync_oe  (fsync_oe),
    .fsync_out (fsync_out),
    .row_addr  (row_addr),
    .row_load  (row_load)
);

// File: tb/test_lcd_scan_timing.sv
module test_lcd_scan_timing;

    logic       clk = 1'b0;
    logic [1:0] strap_sel;
    logic       blank, por, fsync_in;
    logic [2:0] row_addr;
    logic       row_load, phase_b, fsync_out, fsync_oe;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int cyc;
        int row;
        bit ph;
    } load_item_t;

    load_item_t exp_q[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    lcd_scan_timing i_lcd_scan_timing (
        .clk       (clk),
        .strap_sel (strap_sel),
        .blank     (blank),
        .por       (por),
        .fsync_in  (fsync_in),
        .row_addr  (row_addr),
        .row_load  (row_load),
        .phase_b   (phase_b),
        .fsync_out (fsync_out),
        .fsync_oe  (fsync_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver side: expected strobes for rows k_from..k_to of a scan started at base
    task automatic push_scan(input int base, input int k_from, input int k_to,
                             input bit ph0, input bit toggles);
        for (int k = k_from; k <= k_to; k++) begin
            load_item_t it;
            it.cyc = base + 4 * k;
            it.row = k % 8;
            it.ph  = toggles ? (ph0 ^ bit'((k / 8) % 2)) : ph0;
            exp_q.push_back(it);
        end
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // monitor: every strobe must match the next expected item (R5, R6, R8, R9, R10)
    always @(negedge clk) begin
        if (!done && row_load) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8/R9", "unexpected row_load at cycle", cyc, -1);
            end else begin
                load_item_t it;
                it = exp_q.pop_front();
                chk(it.cyc == cyc, "R6", "load cycle", cyc, it.cyc);
                chk(it.row == int'(row_addr), "R5", "row at load", int'(row_addr), it.row);
                chk(it.ph == phase_b, "R10", "phase at load", int'(phase_b), int'(it.ph));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (!done && cyc > 5000) begin
            done = 1'b1;
            chk(1'b0, "WDOG", "run exceeded cycles", cyc, 5000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0, d, m;
        por = 1'b1; blank = 1'b1; strap_sel = 2'b00; fsync_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(row_addr == 3'd0, "R2", "row_addr in reset", int'(row_addr), 0);
        chk(!row_load, "R2", "row_load in reset", int'(row_load), 0);
        chk(!phase_b && !fsync_out, "R2", "phase/fsync in reset", int'(fsync_out), 0);
        chk(fsync_oe, "R1", "master oe for straps 00", int'(fsync_oe), 1);

        // master: release reset
        blank = 1'b0;
        @(negedge clk);
        por = 1'b0;
        n0 = cyc + 1;
        push_scan(n0, 1, 23, 1'b1, 1'b1);
        @(negedge clk);
        chk(fsync_out, "R3", "fsync changed after release", int'(fsync_out), 1);
        chk(row_addr == 3'd0, "R3", "row 000 after release", int'(row_addr), 0);
        chk(phase_b, "R4", "first frame is B", int'(phase_b), 1);
        wait_until(n0 + 31);
        chk(fsync_out, "R7", "fsync held to end of frame", int'(fsync_out), 1);
        @(negedge clk);
        chk(!fsync_out, "R7", "fsync inverted at wrap", int'(fsync_out), 0);
        chk(phase_b == fsync_out, "R7", "phase equals fsync", int'(phase_b), int'(fsync_out));

        // blank while scanning
        wait_until(n0 + 93);
        blank = 1'b1;
        wait_until(n0 + 95);
        for (int i = 0; i < 12; i++) begin
            chk(row_addr == 3'd0, "R8", "row parked in blank", int'(row_addr), 0);
            chk(fsync_out, "R8", "fsync held in blank", int'(fsync_out), 1);
            @(negedge clk);
        end
        d = cyc;
        blank = 1'b0;
        push_scan(d + 1, 1, 9, 1'b0, 1'b1);
        @(negedge clk);
        chk(!fsync_out, "R3", "fsync changed after blank release", int'(fsync_out), 0);
        chk(row_addr == 3'd0, "R3", "row 000 after blank release", int'(row_addr), 0);
        wait_until(d + 38);
        por = 1'b1;
        @(negedge clk);
        chk(row_addr == 3'd0 && !row_load, "R2", "row/load after reset", int'(row_addr), 0);
        chk(!fsync_out && !phase_b, "R2", "fsync after reset", int'(fsync_out), 0);
        chk(exp_q.size() == 0, "R6", "missing master loads", exp_q.size(), 0);

        // slave
        strap_sel = 2'b01;
        @(negedge clk);
        chk(!fsync_oe, "R1", "slave oe for straps 01", int'(fsync_oe), 0);
        por = 1'b0;
        repeat (10) @(negedge clk);
        chk(!row_load && row_addr == 3'd0, "R9", "slave idle before sync", int'(row_load), 0);
        m = cyc;
        fsync_in = 1'b1;
        push_scan(m, 1, 8, 1'b1, 1'b0);
        @(negedge clk);
        chk(phase_b, "R10", "slave phase follows level", int'(phase_b), 1);
        wait_until(m + 34);
        fsync_in = 1'b0;              // late sync change, mid-row
        push_scan(m + 34, 1, 8, 1'b0, 1'b0);
        @(negedge clk);
        chk(!phase_b, "R11", "slave phase after resync", int'(phase_b), 0);
        chk(row_addr == 3'd0, "R11", "slave row after resync", int'(row_addr), 0);
        wait_until(m + 67);
        blank = 1'b1;
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R11", "missing slave loads", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule